// File: doc/BRIEF.md
# Receive Timeout Counter Controller

This block is a loadable down-counter with a sticky counter-ready flag. It serves either as a software-controlled interval timer or as a receive watchdog. In normal mode, software start and stop strobes control the count. A start reloads the counter from the preload input and runs it. A stop halts it and clears the flag. The count steps down once for each count-enable tick. When a tick arrives at zero, the ready flag sets and the counter reloads and keeps running.

A timeout-on strobe puts the block into receive-timeout mode. Entering that mode halts the counter and clears the ready flag. While the mode is active, software start and stop strobes are locked out. Each pulse from the receiver saying that a character has moved from its shift register into its FIFO reloads and restarts the count. If the ready flag then rises, the receive line has been quiet for the programmed interval.

A timeout-off strobe hands control back to the start/stop strobes. It halts nothing and clears nothing, so a stop is needed afterwards to clear a pending flag. The receiver, the bus decode and the tick prescaler sit outside this block.

Top module: `rx_timeout_ctr`

## Requirements
- R1: After reset, ready_o is 0, running_o is 0, tmo_mode_o is 0 and count_o is 0.
- R2: In normal mode (tmo_mode_o = 0), a start_i pulse loads count_o with preload_i and sets running_o on the next clock edge.
- R3: While running_o is 1, each tick_i lowers count_o by one. A tick_i with count_o = 0 sets ready_o and reloads count_o from preload_i, and running_o stays 1. A tick_i while running_o is 0 leaves count_o unchanged.
- R4: Once set, ready_o stays 1 until it is cleared by a normal-mode stop_i or by tmo_on_i. A start_i or a restart by char_xfer_i does not clear it.
- R5: In normal mode, a stop_i pulse clears running_o and ready_o and holds count_o.
- R6: A tmo_on_i pulse sets tmo_mode_o, clears running_o and ready_o, and holds count_o.
- R7: In timeout mode, a char_xfer_i pulse loads count_o with preload_i and sets running_o. In normal mode, char_xfer_i has no effect.
- R8: In timeout mode, start_i and stop_i change neither count_o, running_o nor ready_o.
- R9: A tmo_off_i pulse clears tmo_mode_o and leaves running_o and ready_o unchanged. A later stop_i then clears ready_o.
- R10: Same-cycle priorities: tmo_on_i beats every other input, including tmo_off_i. stop_i beats start_i. A restart beats a terminal tick, so count_o reloads and ready_o is not set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tmo_on_i | input | 1 | Enter receive-timeout mode (strobe) |
| tmo_off_i | input | 1 | Leave receive-timeout mode (strobe) |
| start_i | input | 1 | Software start counter (strobe) |
| stop_i | input | 1 | Software stop counter (strobe) |
| preload_i | input | CNT_W | Reload value |
| tick_i | input | 1 | Count-enable tick |
| char_xfer_i | input | 1 | Receiver moved a character into its FIFO |
| count_o | output | CNT_W | Current count |
| running_o | output | 1 | Counter is running |
| tmo_mode_o | output | 1 | Receive-timeout mode active |
| ready_o | output | 1 | Counter-ready flag |

## Verification
Two functions can fall into the same cycle: a character-transfer restart and the terminal tick that would expire the count. The bench provokes this by letting the count reach zero in timeout mode, then raising tick_i and char_xfer_i on the same edge. It judges the result by requiring count_o to equal the new preload value and ready_o to stay low. The same approach, with two strobes raised on one edge, covers the other priorities: timeout-on against a character, stop against start, and timeout-on against timeout-off.

// File: rtl/tmo_pkg.sv
package tmo_pkg;

   typedef enum logic {
      MODE_NORMAL  = 1'b0,
      MODE_TIMEOUT = 1'b1
   } tmo_mode_e;

endpackage

// File: rtl/tmo_mode_ctl.sv
module tmo_mode_ctl
   import tmo_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic tmo_on_i,
   input  logic tmo_off_i,
   input  logic start_i,
   input  logic stop_i,
   input  logic char_xfer_i,
   output logic tmo_mode_o,
   output logic halt_o,
   output logic restart_o,
   output logic clr_ready_o
);

   tmo_mode_e mode_q;
   logic      in_tmo;
   logic      sw_stop;
   logic      sw_start;
   logic      rx_restart;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          mode_q <= MODE_NORMAL;
      else if (tmo_on_i)   mode_q <= MODE_TIMEOUT;
      else if (tmo_off_i)  mode_q <= MODE_NORMAL;
   end

   assign in_tmo     = (mode_q == MODE_TIMEOUT);
   // software strobes are only honoured in normal mode
   assign sw_stop    = stop_i  && !in_tmo;
   assign sw_start   = start_i && !in_tmo && !stop_i;
   // receive watchdog restart only in timeout mode
   assign rx_restart = char_xfer_i && in_tmo;

   assign halt_o      = tmo_on_i || sw_stop;
   assign restart_o   = !tmo_on_i && (sw_start || rx_restart);
   assign clr_ready_o = tmo_on_i || sw_stop;
   assign tmo_mode_o  = in_tmo;

   assert_on_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (tmo_on_i && tmo_off_i) |=> tmo_mode_o);

   assert_off_mode_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (tmo_off_i && !tmo_on_i) |=> !tmo_mode_o);

endmodule

// File: rtl/tmo_down_counter.sv
module tmo_down_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             halt_i,
   input  logic             restart_i,
   input  logic             tick_i,
   input  logic [CNT_W-1:0] preload_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             run_o,
   output logic             expire_o
);

   localparam logic [CNT_W-1:0] CNT_ZERO = '0;
   localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

   generate
      if (CNT_W < 2 || CNT_W > 32) begin : g_bad_width
         $error("tmo_down_counter: CNT_W must lie in 2..32");
      end
   endgenerate

   logic at_zero;
   logic step;

   assign at_zero  = (cnt_o == CNT_ZERO);
   assign step     = run_o && tick_i && !halt_i && !restart_i;
   assign expire_o = step && at_zero;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_o <= CNT_ZERO;
         run_o <= 1'b0;
      end else if (halt_i) begin
         run_o <= 1'b0;
      end else if (restart_i) begin
         cnt_o <= preload_i;
         run_o <= 1'b1;
      end else if (step) begin
         cnt_o <= at_zero ? preload_i : (cnt_o - CNT_ONE);
      end
   end

   assert_dec_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (run_o && tick_i && !halt_i && !restart_i && cnt_o != CNT_ZERO)
      |=> cnt_o == $past(cnt_o) - CNT_ONE);

   assert_restart_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (restart_i && !halt_i) |=> (run_o && cnt_o == $past(preload_i)));

   assert_halt_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      halt_i |=> (!run_o && cnt_o == $past(cnt_o)));

   assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_o && !restart_i) |=> (cnt_o == $past(cnt_o)));

endmodule

// File: rtl/tmo_ready_flag.sv
module tmo_ready_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic ready_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ready_o <= 1'b0;
      else if (clr_i)  ready_o <= 1'b0;
      else if (set_i)  ready_o <= 1'b1;
   end

   assert_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ready_o && !clr_i) |=> ready_o);

   assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> !ready_o);

endmodule

// File: rtl/rx_timeout_ctr.sv
module rx_timeout_ctr #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tmo_on_i,
   input  logic             tmo_off_i,
   input  logic             start_i,
   input  logic             stop_i,
   input  logic [CNT_W-1:0] preload_i,
   input  logic             tick_i,
   input  logic             char_xfer_i,
   output logic [CNT_W-1:0] count_o,
   output logic             running_o,
   output logic             tmo_mode_o,
   output logic             ready_o
);

   logic halt;
   logic restart;
   logic clr_ready;
   logic expire;

   tmo_mode_ctl u_mode (
      .clk         (clk),
      .rst_n       (rst_n),
      .tmo_on_i    (tmo_on_i),
      .tmo_off_i   (tmo_off_i),
      .start_i     (start_i),
      .stop_i      (stop_i),
      .char_xfer_i (char_xfer_i),
      .tmo_mode_o  (tmo_mode_o),
      .halt_o      (halt),
      .restart_o   (restart),
      .clr_ready_o (clr_ready)
   );

   tmo_down_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .halt_i    (halt),
      .restart_i (restart),
      .tick_i    (tick_i),
      .preload_i (preload_i),
      .cnt_o     (count_o),
      .run_o     (running_o),
      .expire_o  (expire)
   );

   tmo_ready_flag u_flag (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_i   (expire),
      .clr_i   (clr_ready),
      .ready_o (ready_o)
   );

   assert_tmo_locks_sw_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (tmo_mode_o && (start_i || stop_i) && !tmo_on_i && !tmo_off_i
       && !char_xfer_i && !tick_i)
      |=> ($stable(count_o) && $stable(running_o) && $stable(ready_o)));

   assert_char_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (tmo_mode_o && char_xfer_i && !tmo_on_i)
      |=> (running_o && count_o == $past(preload_i)));

   assert_restart_beats_expiry_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (tmo_mode_o && char_xfer_i && !tmo_on_i && tick_i && !ready_o)
      |=> !ready_o);

   assert_tmo_on_halts_R6: assert property (@(posedge clk) disable iff (!rst_n)
      tmo_on_i |=> (tmo_mode_o && !running_o && !ready_o));

endmodule

// File: tb/tb_rx_timeout_ctr.sv
module tb_rx_timeout_ctr;

   localparam int W = 16;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         tmo_on = 1'b0, tmo_off = 1'b0, start = 1'b0, stop = 1'b0;
   logic         tick = 1'b0, chr = 1'b0;
   logic [W-1:0] preload = '0;
   logic [W-1:0] count;
   logic         running, tmo_mode, ready;

   int n_run  = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   rx_timeout_ctr #(.CNT_W(W)) dut (
      .clk(clk), .rst_n(rst_n),
      .tmo_on_i(tmo_on), .tmo_off_i(tmo_off),
      .start_i(start), .stop_i(stop),
      .preload_i(preload), .tick_i(tick), .char_xfer_i(chr),
      .count_o(count), .running_o(running),
      .tmo_mode_o(tmo_mode), .ready_o(ready)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // one clock edge, then back at the falling edge with all strobes low
   task automatic cyc();
      @(posedge clk);
      @(negedge clk);
      tmo_on = 0; tmo_off = 0; start = 0; stop = 0; tick = 0; chr = 0;
   endtask

   task automatic t_reset();
      chk("R1 ready", ready, 0);
      chk("R1 running", running, 0);
      chk("R1 mode", tmo_mode, 0);
      chk("R1 count", count, 0);
   endtask

   task automatic t_normal();
      preload = 3; start = 1; cyc();
      chk("R2 count", count, 3);
      chk("R2 running", running, 1);
      for (int i = 0; i < 3; i++) begin tick = 1; cyc(); end
      chk("R3 count at zero", count, 0);
      chk("R3 ready not yet", ready, 0);
      tick = 1; cyc();
      chk("R3 ready on expiry", ready, 1);
      chk("R3 reload", count, 3);
      chk("R3 still running", running, 1);
      tick = 1; cyc();
      chk("R3 keeps counting", count, 2);
      start = 1; cyc();
      chk("R4 start keeps ready", ready, 1);
      stop = 1; cyc();
      chk("R5 stop running", running, 0);
      chk("R5 stop ready", ready, 0);
      chk("R5 count held", count, 3);
      tick = 1; cyc();
      chk("R3 idle tick", count, 3);
      preload = 7; chr = 1; cyc();
      chk("R7 char ignored normal running", running, 0);
      chk("R7 char ignored normal count", count, 3);
   endtask

   task automatic t_timeout();
      preload = 0; start = 1; cyc();
      tick = 1; cyc();
      chk("R3 ready from zero preload", ready, 1);
      preload = 9; tick = 1; cyc();
      tmo_on = 1; cyc();
      chk("R6 mode", tmo_mode, 1);
      chk("R6 running", running, 0);
      chk("R6 ready", ready, 0);
      chk("R6 count held", count, 9);
      start = 1; cyc();
      chk("R8 start running", running, 0);
      chk("R8 start count", count, 9);
      preload = 2; chr = 1; cyc();
      chk("R7 char count", count, 2);
      chk("R7 char running", running, 1);
      for (int i = 0; i < 3; i++) begin tick = 1; cyc(); end
      chk("R3 timeout expiry", ready, 1);
      stop = 1; cyc();
      chk("R8 stop ready", ready, 1);
      chk("R8 stop running", running, 1);
      chk("R8 stop count", count, 2);
      chr = 1; cyc();
      chk("R4 char keeps ready", ready, 1);
   endtask

   task automatic t_off();
      tmo_off = 1; cyc();
      chk("R9 mode", tmo_mode, 0);
      chk("R9 running kept", running, 1);
      chk("R9 ready kept", ready, 1);
      stop = 1; cyc();
      chk("R9 stop clears ready", ready, 0);
      chk("R9 stop halts", running, 0);
   endtask

   task automatic t_collide();
      tmo_on = 1; cyc();
      preload = 1; chr = 1; cyc();
      tick = 1; cyc();
      chk("R10 count zero", count, 0);
      preload = 5; tick = 1; chr = 1; cyc();
      chk("R10 restart beats expiry count", count, 5);
      chk("R10 restart beats expiry ready", ready, 0);
      chk("R10 restart running", running, 1);
      tmo_on = 1; chr = 1; cyc();
      chk("R10 tmo_on beats char", running, 0);
      tmo_off = 1; cyc();
      start = 1; stop = 1; cyc();
      chk("R10 stop beats start", running, 0);
      tmo_on = 1; tmo_off = 1; cyc();
      chk("R10 tmo_on beats tmo_off", tmo_mode, 1);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1;
      @(negedge clk);
      t_normal();
      t_timeout();
      t_off();
      t_collide();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule